// File: doc/BRIEF.md
# Clock-Crossing Bypass Mailbox

This block carries single messages between two independently clocked ports without touching the main queue storage beside it. It holds two one-word mailboxes. One carries words from side A to side B. The other carries words from side B to side A. Each mailbox has a writer-side "pending" flag and a reader-side "available" flag. Only side A can switch the path on or off. It does this through a chip-select and a 3-bit resource code. The resulting mode is passed into the B clock domain through a synchronizer. There it drives an active-low bypass indicator and gates every side-B transfer.

Each mailbox uses a toggle handshake. The writer flips a toggle and freezes the word. The reader sees the synchronized toggle and captures the word. The reader then flips its own toggle back, and that toggle is synchronized to the writer as the acknowledge. When side A leaves the path, side B may still collect a waiting A-to-B word on the B edge that follows. After that, every unread word is discarded. Both pending flags then settle back to "free", so the next bypass session starts clean.

Top module: `bypass_mailbox`

## Requirements
- R1: Side A's bypass mode is entered on an A edge where `a_sel` is high and `a_res` is 3'b001. It is left on an A edge where `a_sel` is low or `a_res` is 3'b000. Every other resource code with `a_sel` high keeps the current mode.
- R2: `b_byp_n` is low exactly while the bypass mode, carried into the B domain, is active. It changes within three B clock periods of the A edge that changes the mode.
- R3: An A write (`a_wr_en` high) is taken only in bypass mode while `a_full_n` is high. After a taken write, `a_full_n` is low from the next A edge on. Writes presented while it is low are ignored.
- R4: After a taken A write, `b_empty_n` goes high within three B periods. A B read (`b_rd_en` high while `b_empty_n` is high) loads the word into `b_rd_data` and drops `b_empty_n` at that B edge.
- R5: After B consumes or discards the A-to-B word, `a_full_n` returns high within three A periods.
- R6: The B-to-A mailbox mirrors R3 to R5. It uses `b_wr_en`/`b_wr_data`/`b_full_n` on the writer side and `a_rd_en`/`a_rd_data`/`a_empty_n` on the reader side.
- R7: A B read presented in the first B cycle after side A leaves bypass still delivers a waiting A-to-B word.
- R8: When bypass ends, unread words are discarded. `b_empty_n` and `a_empty_n` are low, both full flags return high, and no stale word reappears when bypass is entered again.
- R9: Reads and writes outside bypass mode have no effect. The read data registers keep their value and the flags do not change.
- R10: After reset, `a_full_n` and `b_full_n` are high, `a_empty_n` and `b_empty_n` are low, and `b_byp_n` is high.
- R11: Every taken word is delivered to the reader exactly once, with its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| a_sel | input | 1 | Side A select, active high |
| a_res | input | 3 | Side A resource code (001 bypass, 000 queue) |
| a_wr_en | input | 1 | Side A write strobe into the A-to-B mailbox |
| a_wr_data | input | DATA_W | Side A write word |
| a_full_n | output | 1 | Low while an A-to-B word is pending |
| a_rd_en | input | 1 | Side A read strobe from the B-to-A mailbox |
| a_rd_data | output | DATA_W | Word last read by side A |
| a_empty_n | output | 1 | High while a B-to-A word is available |
| b_wr_en | input | 1 | Side B write strobe into the B-to-A mailbox |
| b_wr_data | input | DATA_W | Side B write word |
| b_full_n | output | 1 | Low while a B-to-A word is pending |
| b_rd_en | input | 1 | Side B read strobe from the A-to-B mailbox |
| b_rd_data | output | DATA_W | Word last read by side B |
| b_empty_n | output | 1 | High while an A-to-B word is available |
| b_byp_n | output | 1 | Bypass indicator in the B domain, active low |

## Verification
The bench builds the block with `DATA_W` = 6 and two synchronizer stages. This makes it practical to send every one of the 64 word codes through each direction, each followed by a blocked second write and a no-duplicate check. The mode decoder is swept over all sixteen select/resource combinations from both starting modes. The unequal A and B clock periods make the exit corner cases reachable: the grace read just after side A leaves, discard of unread words in both directions, and re-entry with no stale word.

// File: rtl/bypass_mailbox_pkg.sv
`timescale 1ns/1ps
package bypass_mailbox_pkg;

  localparam int unsigned RES_W = 3;

  typedef logic [RES_W-1:0] res_code_t;

  localparam res_code_t RES_QUEUE  = 3'b000;
  localparam res_code_t RES_BYPASS = 3'b001;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_ENTER = 2'd1,
    MODE_LEAVE = 2'd2
  } mode_cmd_t;

  // Side A mode command from select and resource code.
  function automatic mode_cmd_t decode_mode(input logic sel, input res_code_t res);
    mode_cmd_t cmd;
    if (!sel)                   cmd = MODE_LEAVE;
    else if (res == RES_BYPASS) cmd = MODE_ENTER;
    else if (res == RES_QUEUE)  cmd = MODE_LEAVE;
    else                        cmd = MODE_HOLD;
    return cmd;
  endfunction

endpackage

// File: rtl/mb_sync.sv
`timescale 1ns/1ps
// Multi-stage flop chain for carrying level signals into a clock domain.
module mb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign pipe_d[s] = d;
    end else begin : g_tail
      assign pipe_d[s] = pipe_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/mb_mode_ctrl.sv
`timescale 1ns/1ps
// Side A bypass mode register.
module mb_mode_ctrl
  import bypass_mailbox_pkg::*;
(
  input  logic      clk_a,
  input  logic      rst_a_n,
  input  logic      a_sel,
  input  res_code_t a_res,
  output logic      byp_q
);

  logic byp_d;

  always_comb begin
    byp_d = byp_q;
    case (decode_mode(a_sel, a_res))
      MODE_ENTER: byp_d = 1'b1;
      MODE_LEAVE: byp_d = 1'b0;
      default:    byp_d = byp_q;
    endcase
  end

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) byp_q <= 1'b0;
    else          byp_q <= byp_d;
  end

  // R1: offset-register codes leave the mode alone
  p_other_res_hold_r1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_sel && a_res[2]) |=> $stable(byp_q));

  // R1: deselect always ends the mode
  p_deselect_leaves_r1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !a_sel |=> !byp_q);

endmodule

// File: rtl/mb_channel.sv
`timescale 1ns/1ps
// One-word mailbox with toggle handshake between a writer and a reader clock.
module mb_channel #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              w_active,
  input  logic              w_en,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_full_n,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              r_active,
  input  logic              r_en,
  output logic [DATA_W-1:0] r_data,
  output logic              r_empty_n
);

  // ---------------- writer side ----------------
  logic              w_tgl_q, w_tgl_d;
  logic [DATA_W-1:0] w_hold_q;
  logic              w_ack_s;
  logic              w_take;
  logic              r_tgl_q, r_tgl_d;

  mb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(wclk), .rst_n(wrst_n), .d(r_tgl_q), .q(w_ack_s)
  );

  assign w_full_n = (w_tgl_q == w_ack_s);
  assign w_take   = w_active & w_en & w_full_n;

  always_comb begin
    w_tgl_d = w_tgl_q;
    if (w_take) w_tgl_d = ~w_tgl_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      w_tgl_q  <= 1'b0;
      w_hold_q <= '0;
    end else begin
      w_tgl_q <= w_tgl_d;
      if (w_take) w_hold_q <= w_data;
    end
  end

  // ---------------- reader side ----------------
  logic r_wtgl_s;
  logic r_pend;
  logic r_take;

  mb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rclk), .rst_n(rrst_n), .d(w_tgl_q), .q(r_wtgl_s)
  );

  assign r_pend    = r_wtgl_s ^ r_tgl_q;
  assign r_empty_n = r_active & r_pend;
  assign r_take    = r_active & r_en & r_pend;

  // Outside the mode any arriving word is absorbed (discarded).
  always_comb begin
    r_tgl_d = r_tgl_q;
    if (!r_active)   r_tgl_d = r_wtgl_s;
    else if (r_take) r_tgl_d = ~r_tgl_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      r_tgl_q <= 1'b0;
      r_data  <= '0;
    end else begin
      r_tgl_q <= r_tgl_d;
      if (r_take) r_data <= w_hold_q;
    end
  end

  // R3: a taken write marks the mailbox pending at once
  p_take_sets_full_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_take |=> !w_full_n);

  // R3: the held word cannot change while pending
  p_full_freezes_word_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    !w_full_n |=> $stable(w_hold_q));

  // R4: a read drains the mailbox on that edge
  p_read_drains_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    r_take |=> !r_empty_n);

  // R9: outside the mode the read register is untouched
  p_idle_keeps_data_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
    !r_active |=> $stable(r_data));

endmodule

// File: rtl/bypass_mailbox.sv
`timescale 1ns/1ps
// Pair of clock-crossing one-word mailboxes under side A mode control.
module bypass_mailbox
  import bypass_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic [2:0]        a_res,
  input  logic              a_wr_en,
  input  logic [DATA_W-1:0] a_wr_data,
  output logic              a_full_n,
  input  logic              a_rd_en,
  output logic [DATA_W-1:0] a_rd_data,
  output logic              a_empty_n,
  input  logic              b_wr_en,
  input  logic [DATA_W-1:0] b_wr_data,
  output logic              b_full_n,
  input  logic              b_rd_en,
  output logic [DATA_W-1:0] b_rd_data,
  output logic              b_empty_n,
  output logic              b_byp_n
);

  logic rst_a_n;
  logic rst_b_n;
  logic a_byp_q;
  logic b_byp_s;

  // reset asserted asynchronously, released on each domain's clock
  mb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_a (
    .clk(clk_a), .rst_n(rst_n), .d(1'b1), .q(rst_a_n)
  );
  mb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_b (
    .clk(clk_b), .rst_n(rst_n), .d(1'b1), .q(rst_b_n)
  );

  mb_mode_ctrl u_mode (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .a_sel(a_sel), .a_res(a_res), .byp_q(a_byp_q)
  );

  mb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_mode_sync (
    .clk(clk_b), .rst_n(rst_b_n), .d(a_byp_q), .q(b_byp_s)
  );

  assign b_byp_n = ~b_byp_s;

  mb_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ab (
    .wclk(clk_a), .wrst_n(rst_a_n), .w_active(a_byp_q), .w_en(a_wr_en),
    .w_data(a_wr_data), .w_full_n(a_full_n),
    .rclk(clk_b), .rrst_n(rst_b_n), .r_active(b_byp_s), .r_en(b_rd_en),
    .r_data(b_rd_data), .r_empty_n(b_empty_n)
  );

  mb_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ba (
    .wclk(clk_b), .wrst_n(rst_b_n), .w_active(b_byp_s), .w_en(b_wr_en),
    .w_data(b_wr_data), .w_full_n(b_full_n),
    .rclk(clk_a), .rrst_n(rst_a_n), .r_active(a_byp_q), .r_en(a_rd_en),
    .r_data(a_rd_data), .r_empty_n(a_empty_n)
  );

  // R2: the B-side indicator only moves toward the A-side mode
  p_indicator_tracks_r2: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $fell(b_byp_n) |-> $past(a_byp_q));

endmodule

// File: tb/bypass_mailbox_test.sv
`timescale 1ns/1ps
module bypass_mailbox_test;

  localparam int unsigned DW = 6;

  logic          clk_a = 1'b0;
  logic          clk_b = 1'b0;
  logic          rst_n;
  logic          a_sel;
  logic [2:0]    a_res;
  logic          a_wr_en;
  logic [DW-1:0] a_wr_data;
  logic          a_full_n;
  logic          a_rd_en;
  logic [DW-1:0] a_rd_data;
  logic          a_empty_n;
  logic          b_wr_en;
  logic [DW-1:0] b_wr_data;
  logic          b_full_n;
  logic          b_rd_en;
  logic [DW-1:0] b_rd_data;
  logic          b_empty_n;
  logic          b_byp_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4    clk_a = ~clk_a;
  always #5.5  clk_b = ~clk_b;

  bypass_mailbox #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_sel(a_sel), .a_res(a_res),
    .a_wr_en(a_wr_en), .a_wr_data(a_wr_data), .a_full_n(a_full_n),
    .a_rd_en(a_rd_en), .a_rd_data(a_rd_data), .a_empty_n(a_empty_n),
    .b_wr_en(b_wr_en), .b_wr_data(b_wr_data), .b_full_n(b_full_n),
    .b_rd_en(b_rd_en), .b_rd_data(b_rd_data), .b_empty_n(b_empty_n),
    .b_byp_n(b_byp_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic sel, input logic [2:0] res);
    @(negedge clk_a);
    a_sel = sel;
    a_res = res;
  endtask

  task automatic wait_byp(input logic level, output int n);
    n = 99;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk_b);
      if (b_byp_n == level) begin n = i; break; end
    end
  endtask

  task automatic wait_b_empty_hi(output bit seen);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_b);
      if (b_empty_n) begin seen = 1; break; end
    end
  endtask

  task automatic wait_a_empty_hi(output bit seen);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_a);
      if (a_empty_n) begin seen = 1; break; end
    end
  endtask

  task automatic wait_a_free(output int n);
    n = 99;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk_a);
      if (a_full_n) begin n = i; break; end
    end
  endtask

  task automatic wait_b_free(output int n);
    n = 99;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk_b);
      if (b_full_n) begin n = i; break; end
    end
  endtask

  // A to B word, with a blocked second write and a duplicate check
  task automatic ab_word(input logic [DW-1:0] v);
    bit seen;
    int n;
    @(negedge clk_a);
    a_wr_en = 1'b1; a_wr_data = v;
    @(negedge clk_a);
    check("R3 full after write", a_full_n, 0);
    a_wr_data = ~v;
    @(negedge clk_a);
    a_wr_en = 1'b0;
    check("R3 blocked write keeps full", a_full_n, 0);
    wait_b_empty_hi(seen);
    check("R4 word available", seen, 1);
    b_rd_en = 1'b1;
    @(negedge clk_b);
    b_rd_en = 1'b0;
    check("R11 AB word value", b_rd_data, v);
    check("R4 empty after read", b_empty_n, 0);
    wait_a_free(n);
    check("R5 full clears within 3", n <= 3, 1);
    repeat (6) @(negedge clk_b);
    check("R11 AB no duplicate", b_empty_n, 0);
  endtask

  task automatic ba_word(input logic [DW-1:0] v);
    bit seen;
    int n;
    @(negedge clk_b);
    b_wr_en = 1'b1; b_wr_data = v;
    @(negedge clk_b);
    check("R6 full after write", b_full_n, 0);
    b_wr_data = ~v;
    @(negedge clk_b);
    b_wr_en = 1'b0;
    check("R6 blocked write keeps full", b_full_n, 0);
    wait_a_empty_hi(seen);
    check("R6 word available", seen, 1);
    a_rd_en = 1'b1;
    @(negedge clk_a);
    a_rd_en = 1'b0;
    check("R11 BA word value", a_rd_data, v);
    check("R6 empty after read", a_empty_n, 0);
    wait_b_free(n);
    check("R6 full clears within 3", n <= 3, 1);
    repeat (6) @(negedge clk_a);
    check("R11 BA no duplicate", a_empty_n, 0);
  endtask

  initial begin
    int n;
    bit seen;
    logic [DW-1:0] keep;
    rst_n = 1'b0;
    a_sel = 0; a_res = 3'b000; a_wr_en = 0; a_wr_data = '0; a_rd_en = 0;
    b_wr_en = 0; b_wr_data = '0; b_rd_en = 0;
    repeat (4) @(negedge clk_a);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_b);

    check("R10 a_full_n", a_full_n, 1);
    check("R10 b_full_n", b_full_n, 1);
    check("R10 a_empty_n", a_empty_n, 0);
    check("R10 b_empty_n", b_empty_n, 0);
    check("R10 b_byp_n", b_byp_n, 1);

    // R9: transfers outside bypass are ignored
    @(negedge clk_a); a_wr_en = 1; a_wr_data = 6'h2A; a_rd_en = 1;
    @(negedge clk_b); b_wr_en = 1; b_wr_data = 6'h15; b_rd_en = 1;
    repeat (4) @(negedge clk_b);
    b_wr_en = 0; b_rd_en = 0;
    @(negedge clk_a); a_wr_en = 0; a_rd_en = 0;
    check("R9 a_full_n idle", a_full_n, 1);
    check("R9 b_full_n idle", b_full_n, 1);
    check("R9 a_rd_data idle", a_rd_data, 0);
    check("R9 b_rd_data idle", b_rd_data, 0);

    // R1/R2: mode decode sweep from both starting modes
    for (int init = 0; init < 2; init++) begin
      for (int sel = 0; sel < 2; sel++) begin
        for (int res = 0; res < 8; res++) begin
          logic exp_on;
          set_mode(1'b1, init[0] ? 3'b001 : 3'b000);
          repeat (6) @(negedge clk_b);
          set_mode(sel[0], res[2:0]);
          repeat (6) @(negedge clk_b);
          if (sel[0] && res == 1)       exp_on = 1'b1;
          else if (!sel[0] || res == 0) exp_on = 1'b0;
          else                          exp_on = init[0];
          check("R1 mode decode", b_byp_n, !exp_on);
        end
      end
    end
    check("R9 no word leaked by mode sweep", b_empty_n, 0);

    // R2: indicator latency on entry and exit
    set_mode(1'b1, 3'b000);
    repeat (6) @(negedge clk_b);
    set_mode(1'b1, 3'b001);
    wait_byp(1'b0, n);
    check("R2 entry latency", n <= 3, 1);
    set_mode(1'b0, 3'b001);
    wait_byp(1'b1, n);
    check("R2 exit latency", n <= 3, 1);
    set_mode(1'b1, 3'b001);
    wait_byp(1'b0, n);
    check("R2 re-entry", b_byp_n, 0);
    // outside-bypass writes issued earlier must not surface (R9)
    check("R9 no stale AB", b_empty_n, 0);
    check("R9 no stale BA", a_empty_n, 0);

    // R3..R6, R11: every code in both directions
    for (int v = 0; v < 64; v++) ab_word(v[DW-1:0]);
    for (int v = 0; v < 64; v++) ba_word(v[DW-1:0] ^ 6'h2B);

    // R7: read right after A leaves still gets the word
    @(negedge clk_a); a_wr_en = 1; a_wr_data = 6'h33;
    @(negedge clk_a); a_wr_en = 0;
    wait_b_empty_hi(seen);
    check("R7 word waiting", seen, 1);
    set_mode(1'b1, 3'b000);
    @(negedge clk_b); b_rd_en = 1;
    @(negedge clk_b); b_rd_en = 0;
    check("R7 grace read value", b_rd_data, 6'h33);
    wait_byp(1'b1, n);
    check("R7 indicator released", b_byp_n, 1);
    wait_a_free(n);
    check("R7 writer freed", a_full_n, 1);

    // R8: unread A-to-B word discarded on exit
    set_mode(1'b1, 3'b001);
    wait_byp(1'b0, n);
    @(negedge clk_a); a_wr_en = 1; a_wr_data = 6'h0C;
    @(negedge clk_a); a_wr_en = 0;
    wait_b_empty_hi(seen);
    check("R8 word waiting", seen, 1);
    set_mode(1'b0, 3'b000);
    wait_byp(1'b1, n);
    check("R8 empty dropped at exit", b_empty_n, 0);
    keep = b_rd_data;
    @(negedge clk_b); b_rd_en = 1;
    @(negedge clk_b); b_rd_en = 0;
    check("R9 read outside bypass ignored", b_rd_data, keep);
    wait_a_free(n);
    check("R8 A writer freed", a_full_n, 1);
    set_mode(1'b1, 3'b001);
    wait_byp(1'b0, n);
    repeat (4) @(negedge clk_b);
    check("R8 no stale AB after re-entry", b_empty_n, 0);

    // R8: unread B-to-A word discarded on exit
    @(negedge clk_b); b_wr_en = 1; b_wr_data = 6'h21;
    @(negedge clk_b); b_wr_en = 0;
    wait_a_empty_hi(seen);
    check("R8 BA word waiting", seen, 1);
    set_mode(1'b0, 3'b000);
    @(negedge clk_a);
    check("R8 a_empty_n dropped at exit", a_empty_n, 0);
    wait_byp(1'b1, n);
    wait_b_free(n);
    check("R8 B writer freed", b_full_n, 1);
    set_mode(1'b1, 3'b001);
    wait_byp(1'b0, n);
    repeat (4) @(negedge clk_a);
    check("R8 no stale BA after re-entry", a_empty_n, 0);
    ab_word(6'h3E);
    ba_word(6'h01);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_a);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule